// File: doc/BRIEF.md
# Serial Frame Receiver with Address Wake-up

This block receives asynchronous serial frames on a single line and hands each finished frame to a CPU through a one-entry receive buffer. The line is sampled on a 16x oversampling tick. A 2-bit mode input selects 7, 8 or 9 data bits. In 7- and 8-bit modes an optional parity bit follows the data. One stop bit always ends the frame. A separate ninth-bit register has two uses. In 9-bit mode it holds the most significant data bit. When parity is enabled in a shorter mode, it holds the received parity bit.

The CPU reads the frame through a read strobe, which empties the buffer. Three sticky error flags report parity, framing and overrun errors. A one-cycle interrupt pulse marks each stored frame. In 9-bit mode an address wake-up option suppresses that pulse for frames whose ninth bit is clear. A slave node can then sleep through data frames addressed to other nodes and wake only on address frames.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, the buffer-full flag, the three error flags, the interrupt, the data output and the ninth-bit output are all 0.
- R2: In 8-bit mode (mode_i = 1), a frame is received LSB first and stored in data_o. full_o is set, and irq_o pulses for one cycle.
- R3: In 7-bit mode (mode_i = 0), exactly 7 data bits are received, and data_o[7] reads 0.
- R4: In 9-bit mode (mode_i = 2), data_o holds the low 8 data bits and bit9_o holds the ninth (last) data bit. No parity bit is expected in this mode.
- R5: With par_en_i set in 7- or 8-bit mode, the parity bit that follows the data is stored in bit9_o. perr_o is set when the count of ones in data plus parity is odd with par_odd_i = 0, or even with par_odd_i = 1.
- R6: A stop bit sampled as 0 sets ferr_o. The frame is still stored and signalled.
- R7: A frame that completes while full_o is 1 sets oerr_o. The new frame is discarded, the old data is kept and no interrupt is raised. If rd_i is asserted in the completion cycle, the read is taken first: the new frame is stored and no overrun is flagged.
- R8: A pulse on rd_i clears full_o.
- R9: With wake_en_i set in 9-bit mode, a stored frame raises irq_o only when its ninth bit is 1. The frame is stored either way. In 7- and 8-bit modes wake_en_i has no effect.
- R10: A start bit is accepted only when the majority of samples 7, 8 and 9 (of 16) is 0. A shorter low pulse returns the receiver to idle without storing anything.
- R11: Error flags stay set until they are cleared. err_clr_i clears them only if stat_rd_i has been pulsed since the last clear. Otherwise it has no effect.
- R12: With rx_en_i low, no start bit is searched for. Dropping rx_en_i in mid-frame aborts the frame, and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 16x oversampling enable |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| mode_i | input | 2 | 0: 7-bit, 1: 8-bit, 2: 9-bit, 3: as 8-bit |
| par_en_i | input | 1 | Parity enable (7/8-bit modes) |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| wake_en_i | input | 1 | Address wake-up enable |
| rd_i | input | 1 | Buffer read strobe |
| stat_rd_i | input | 1 | Status read strobe, arms error clearing |
| err_clr_i | input | 1 | Error flag clear strobe |
| data_o | output | 8 | Received data |
| bit9_o | output | 1 | Ninth bit: parity or data MSB |
| full_o | output | 1 | Buffer holds an unread frame |
| perr_o | output | 1 | Parity error flag |
| ferr_o | output | 1 | Framing error flag |
| oerr_o | output | 1 | Overrun error flag |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
A buffer read and a frame completion can fall in the same clock cycle. The outcome decides whether the frame is stored or counted as an overrun. The bench first receives a frame into an empty buffer and records the cycle in which full_o rises. It then sends an identical-timing frame while the buffer is full, with rd_i pulsed in exactly that completion cycle. It expects the new data in data_o, oerr_o clear and one more interrupt. A plain overrun without the read serves as the contrasting case.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;
  typedef enum logic [1:0] {MODE_7 = 2'd0, MODE_8 = 2'd1, MODE_9 = 2'd2} dmode_e;
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;
  localparam int MAX_BITS = 9;
  localparam int IDX_W    = 4;
endpackage

// File: rtl/uart_wake_rx_sampler.sv
module uart_wake_rx_sampler #(
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic run_i,
  output logic rx_s_o,
  output logic mid_o,
  output logic maj_o,
  output logic end_o
);
  localparam int CW  = $clog2(OS);
  localparam int MID = OS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rx_i;
    end
  endgenerate
  assign rx_s_o = sync_q[SYNC_STAGES-1];

  logic [CW-1:0] cnt_q;
  logic [1:0]    smp_q;

  // idle tick that saw the edge is sample 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(1);
      smp_q <= 2'b11;
    end else if (!run_i) begin
      cnt_q <= CW'(1);
    end else if (tick_i) begin
      cnt_q <= (cnt_q == CW'(OS-1)) ? '0 : cnt_q + CW'(1);
      if (cnt_q == CW'(MID-1)) smp_q[0] <= rx_s_o;
      if (cnt_q == CW'(MID))   smp_q[1] <= rx_s_o;
    end
  end

  assign mid_o = run_i && tick_i && (cnt_q == CW'(MID+1));
  assign end_o = run_i && tick_i && (cnt_q == CW'(OS-1));
  assign maj_o = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_s_o) | (smp_q[1] & rx_s_o);

  a_r10_mid_end_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mid_o && end_o));
endmodule

// File: rtl/uart_wake_rx_frame.sv
module uart_wake_rx_frame
  import uart_wake_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_s_i,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       mid_i,
  input  logic       maj_i,
  input  logic       end_i,
  output logic       run_o,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       perr_o,
  output logic       ferr_o
);
  rx_state_e           state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [MAX_BITS-1:0] sh_q;
  logic                mode7, mode9, use_par;
  logic [IDX_W-1:0]    nd_c, last_c;

  assign mode7   = (mode_i == MODE_7);
  assign mode9   = (mode_i == MODE_9);
  assign use_par = par_en_i && !mode9;
  assign nd_c    = mode7 ? IDX_W'(7) : (mode9 ? IDX_W'(9) : IDX_W'(8));
  assign last_c  = nd_c + IDX_W'(use_par) - IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (!en_i) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (tick_i && !rx_s_i) begin
          state_q <= S_START;
          sh_q    <= '0;
        end
        S_START: begin
          if (mid_i && maj_i) state_q <= S_IDLE;
          else if (end_i) begin
            state_q <= S_DATA;
            idx_q   <= '0;
          end
        end
        S_DATA: begin
          if (mid_i) sh_q[idx_q] <= maj_i;
          if (end_i) begin
            if (idx_q == last_c) state_q <= S_STOP;
            else                 idx_q   <= idx_q + IDX_W'(1);
          end
        end
        S_STOP: if (mid_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q != S_IDLE);
  assign done_o = en_i && (state_q == S_STOP) && mid_i;
  assign data_o = mode7 ? {1'b0, sh_q[6:0]} : sh_q[7:0];
  assign bit9_o = mode9 ? sh_q[8] : (use_par ? sh_q[nd_c] : 1'b0);
  assign perr_o = use_par && ((^data_o ^ bit9_o) != par_odd_i);
  assign ferr_o = !maj_i;

  a_r12_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == S_IDLE);
  a_r10_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START && mid_i && maj_i) |=> state_q == S_IDLE);
endmodule

// File: rtl/uart_wake_rx_buf.sv
module uart_wake_rx_buf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic [7:0] data_i,
  input  logic       bit9_i,
  input  logic       perr_i,
  input  logic       ferr_i,
  input  logic       mode9_i,
  input  logic       wake_en_i,
  input  logic       rd_i,
  input  logic       stat_rd_i,
  input  logic       clr_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       full_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       oerr_o,
  output logic       irq_o
);
  logic [7:0] data_q;
  logic       bit9_q, full_q, perr_q, ferr_q, oerr_q, irq_q, arm_q;
  logic       store, ovr, clr_ok;

  assign store  = done_i && (!full_q || rd_i);   // same-cycle read wins
  assign ovr    = done_i && full_q && !rd_i;
  assign clr_ok = clr_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      oerr_q <= 1'b0;
      irq_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (store) begin
        data_q <= data_i;
        bit9_q <= bit9_i;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      perr_q <= (store && perr_i) ? 1'b1 : (clr_ok ? 1'b0 : perr_q);
      ferr_q <= (store && ferr_i) ? 1'b1 : (clr_ok ? 1'b0 : ferr_q);
      oerr_q <= ovr               ? 1'b1 : (clr_ok ? 1'b0 : oerr_q);
      irq_q  <= store && (!(wake_en_i && mode9_i) || bit9_i);
      if (clr_i)          arm_q <= 1'b0;
      else if (stat_rd_i) arm_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign bit9_o = bit9_q;
  assign full_o = full_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign oerr_o = oerr_q;
  assign irq_o  = irq_q;

  a_r8_read_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !full_q);
  a_r7_overrun_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_q && !rd_i) |=> (oerr_q && $stable(data_q) && !irq_q));
  a_r9_wake_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && $past(wake_en_i && mode9_i)) |-> bit9_q);
  a_r11_sticky_perr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_q && !(clr_i && arm_q)) |=> perr_q);
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_rx_pkg::*;
#(
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       rx_en_i,
  input  logic [1:0] mode_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       wake_en_i,
  input  logic       rd_i,
  input  logic       stat_rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       full_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       oerr_o,
  output logic       irq_o
);
  logic       rx_s, run, mid, maj, fin, done;
  logic [7:0] f_data;
  logic       f_bit9, f_perr, f_ferr;

  uart_wake_rx_sampler #(.OS(OS), .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk_i, .rst_ni, .tick_i, .rx_i,
    .run_i(run), .rx_s_o(rx_s), .mid_o(mid), .maj_o(maj), .end_o(fin)
  );

  uart_wake_rx_frame u_frm (
    .clk_i, .rst_ni, .tick_i,
    .rx_s_i(rx_s), .en_i(rx_en_i), .mode_i, .par_en_i, .par_odd_i,
    .mid_i(mid), .maj_i(maj), .end_i(fin),
    .run_o(run), .done_o(done), .data_o(f_data), .bit9_o(f_bit9),
    .perr_o(f_perr), .ferr_o(f_ferr)
  );

  uart_wake_rx_buf u_buf (
    .clk_i, .rst_ni,
    .done_i(done), .data_i(f_data), .bit9_i(f_bit9), .perr_i(f_perr), .ferr_i(f_ferr),
    .mode9_i(mode_i == MODE_9), .wake_en_i, .rd_i, .stat_rd_i, .clr_i(err_clr_i),
    .data_o, .bit9_o, .full_o, .perr_o, .ferr_o, .oerr_o, .irq_o
  );
endmodule

// File: tb/uart_wake_rx_tb_top.sv
module uart_wake_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rx = 1'b1, rx_en = 1'b1;
  logic [1:0] mode = 2'd1;
  logic       par_en = 1'b0, par_odd = 1'b0, wake_en = 1'b0;
  logic       rd = 1'b0, stat_rd = 1'b0, err_clr = 1'b0;
  logic [7:0] data;
  logic       bit9, full, perr, ferr, oerr, irq;

  int checks = 0, errors = 0, irq_cnt = 0, exp_irq = 0;

  always #2 clk = ~clk;

  uart_wake_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx), .rx_en_i(rx_en),
    .mode_i(mode), .par_en_i(par_en), .par_odd_i(par_odd), .wake_en_i(wake_en),
    .rd_i(rd), .stat_rd_i(stat_rd), .err_clr_i(err_clr),
    .data_o(data), .bit9_o(bit9), .full_o(full), .perr_o(perr), .ferr_o(ferr),
    .oerr_o(oerr), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one frame, 16 cycles per bit (tick every cycle)
  task automatic frame(input logic [8:0] pay, input int nd, input bit hp, input bit pb,
                       input bit stopv, input int rd_at, input int en_off_at,
                       output int first_full);
    logic [11:0] vec;
    int nb;
    vec = '1;
    vec[0] = 1'b0;
    for (int i = 0; i < nd; i++) vec[1+i] = pay[i];
    if (hp) vec[1+nd] = pb;
    nb = 1 + nd + int'(hp) + 1;
    vec[nb-1] = stopv;
    first_full = -1;
    for (int c = 0; c < nb*16 + 8; c++) begin
      @(negedge clk);
      if (full && first_full < 0) first_full = c;
      rx    = (c < nb*16) ? vec[c/16] : 1'b1;
      rd    = (c == rd_at);
      rx_en = !(en_off_at >= 0 && c >= en_off_at);
    end
    @(negedge clk);
    rd = 1'b0;
    rx = 1'b1;
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic clear_errs();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) begin stat_rd = 1'b0; err_clr = 1'b1; end
    @(negedge clk) err_clr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ff, k;
    logic [8:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 full", full, 0);   chk("R1 perr", perr, 0);
    chk("R1 ferr", ferr, 0);   chk("R1 oerr", oerr, 0);
    chk("R1 data", data, 0);   chk("R1 bit9", bit9, 0);
    chk("R1 irq", irq_cnt, 0);

    // R2: 8-bit sweep
    mode = 2'd1;
    for (int v = 0; v < 256; v += 23) begin
      frame(9'(v), 8, 0, 0, 1, -1, -1, ff);
      exp_irq++;
      chk("R2 data", data, v); chk("R2 full", full, 1); chk("R2 irq", irq_cnt, exp_irq);
      pulse_rd();
      chk("R8 full cleared", full, 0);
    end

    // R3: 7-bit sweep
    mode = 2'd0;
    for (int v = 0; v < 256; v += 37) begin
      frame(9'(v), 7, 0, 0, 1, -1, -1, ff);
      exp_irq++;
      chk("R3 data", data, v & 8'h7f); chk("R3 bit9", bit9, 0);
      pulse_rd();
    end

    // R4: 9-bit sweep
    mode = 2'd2;
    for (int v = 0; v < 512; v += 61) begin
      frame(9'(v), 9, 0, 0, 1, -1, -1, ff);
      exp_irq++;
      chk("R4 data", data, v & 8'hff); chk("R4 bit9", bit9, (v >> 8) & 1);
      chk("R4 irq", irq_cnt, exp_irq);
      pulse_rd();
    end

    // R5: parity, both senses, good and bad, 7 and 8 bit
    par_en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m);
      for (int odd = 0; odd < 2; odd++) begin
        par_odd = 1'(odd);
        for (int v = 5; v < 256; v += 83) begin
          for (int bad = 0; bad < 2; bad++) begin
            int nd, ones, good;
            nd = 7 + m;
            ones = $countones(v & ((1 << nd) - 1));
            good = (ones + odd) & 1;  // makes total ones parity match sense
            frame(9'(v), nd, 1, 1'(good ^ bad), 1, -1, -1, ff);
            exp_irq++;
            chk("R5 bit9", bit9, good ^ bad);
            chk("R5 perr", perr, bad);
            pulse_rd();
            clear_errs();
            chk("R11 perr cleared", perr, 0);
          end
        end
      end
    end
    par_en = 1'b0;

    // R6 framing, R11 clear needs status read
    mode = 2'd1;
    frame(9'h5a, 8, 0, 0, 0, -1, -1, ff);
    exp_irq++;
    chk("R6 ferr", ferr, 1); chk("R6 stored", data, 8'h5a); chk("R6 irq", irq_cnt, exp_irq);
    pulse_rd();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    chk("R11 clr w/o status read", ferr, 1);
    clear_errs();
    chk("R11 ferr cleared", ferr, 0);

    // R7 overrun
    frame(9'h33, 8, 0, 0, 1, -1, -1, k);
    exp_irq++;
    frame(9'hc4, 8, 0, 0, 1, -1, -1, ff);
    chk("R7 oerr", oerr, 1); chk("R7 old data", data, 8'h33); chk("R7 no irq", irq_cnt, exp_irq);
    pulse_rd();
    clear_errs();
    chk("R11 oerr cleared", oerr, 0);

    // R7 read in completion cycle
    frame(9'h71, 8, 0, 0, 1, -1, -1, k);
    exp_irq++;
    frame(9'h8e, 8, 0, 0, 1, k - 1, -1, ff);
    exp_irq++;
    chk("R7 same-cycle oerr", oerr, 0); chk("R7 same-cycle data", data, 8'h8e);
    chk("R7 same-cycle full", full, 1); chk("R7 same-cycle irq", irq_cnt, exp_irq);
    pulse_rd();

    // R9 wake-up
    wake_en = 1'b1;
    mode = 2'd2;
    frame(9'h042, 9, 0, 0, 1, -1, -1, ff);
    chk("R9 data frame stored", full, 1); chk("R9 no irq", irq_cnt, exp_irq);
    chk("R9 data", data, 8'h42);
    pulse_rd();
    frame(9'h1a5, 9, 0, 0, 1, -1, -1, ff);
    exp_irq++;
    chk("R9 address irq", irq_cnt, exp_irq);
    pulse_rd();
    mode = 2'd1;
    frame(9'h012, 8, 0, 0, 1, -1, -1, ff);
    exp_irq++;
    chk("R9 ignored in 8-bit", irq_cnt, exp_irq);
    pulse_rd();
    wake_en = 1'b0;

    // R10 false start
    @(negedge clk) rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (200) @(negedge clk);
    chk("R10 no frame", full, 0); chk("R10 no irq", irq_cnt, exp_irq);
    frame(9'h3c, 8, 0, 0, 1, -1, -1, ff);
    exp_irq++;
    chk("R10 recovers", data, 8'h3c);
    pulse_rd();

    // R12 receive enable
    frame(9'h99, 8, 0, 0, 1, -1, 0, ff);
    chk("R12 disabled", full, 0);
    frame(9'h99, 8, 0, 0, 1, -1, 80, ff);
    chk("R12 aborted", full, 0); chk("R12 no irq", irq_cnt, exp_irq);
    chk("R12 data kept", data, 8'h3c);
    a = 9'h0e7;
    frame(a, 8, 0, 0, 1, -1, -1, ff);
    exp_irq++;
    chk("R12 resumes", data, 8'he7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule